// File: doc/BRIEF.md
# Minimal Stored-Program Processor Core

This block is a small multi-cycle processor. Instructions and data share one byte-wide memory reached through a synchronous single-port bus. The core keeps a program counter, an instruction register and four 8-bit general registers. It repeats a fixed loop: it fetches a 16-bit instruction as two bytes, decodes it, and then executes it. The instruction set is small. It can move a byte from memory into a register, move a register out to memory, add two registers into a third, jump always, jump when a register holds zero, and stop.

A system places a program at address 0, releases reset and waits for the halt flag. Results appear only as memory writes on the bus. Because code and data live in the same memory, a program can read its own instruction bytes as data. Any instruction the core cannot interpret stops the machine in the same way as an explicit stop.

Top module: `tiny_cpu`

## Requirements
- R1: While reset is high and on the first cycle after it falls, the core drives address 0 with write enable low and the halt flag low. Reset clears the program counter, the instruction register and every general register to 0.
- R2: A fetch reads the byte at PC (the high half of the instruction) and then the byte at PC+1 (the low half) on consecutive cycles, and PC advances by 2.
- R3: LOAD uses opcode bits[15:12]=0001, destination register in bits[11:8] and memory address in bits[7:0]. The register receives the byte read from that address, which may be an instruction byte.
- R4: STORE uses opcode 0010, source register in bits[11:8] and address in bits[7:0]. It raises write enable for exactly one cycle, with that address and the register value on the bus.
- R5: ADD uses opcode 1001, with the first source in bits[11:8], the second source in bits[7:4] and the destination in bits[3:0]. The 8-bit sum wraps modulo 256, so 0xFF+0x01 gives 0x00.
- R6: JUMP uses opcode 1010 and loads PC with bits[7:0]. The register field is ignored.
- R7: Jump-if-zero uses opcode 1011, with the tested register in bits[11:8] and the target in bits[7:0]. It loads PC only when that register is 0. Otherwise execution continues with the next instruction.
- R8: HALT (opcode 1111) sets the halt flag, which then stays set. After that no write happens, and the bus address stays on the address after the halting instruction.
- R9: Any opcode other than 0001, 0010, 1001, 1010, 1011 or 1111 behaves like HALT.
- R10: A register field with a value of 4 or more, in any field the instruction uses, behaves like HALT. No write is made for that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Byte address for reads and writes |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write enable for the addressed byte |
| mem_rdata | input | 8 | Byte read, valid one cycle after its address |
| halted | output | 1 | Core has stopped |

## Verification
The register file can only be seen through STORE. This makes two things hard to check: the clearing done by reset and the choice of destination register. The bench runs a program that leaves nonzero values in registers, then resets and stores those same registers, expecting zeros. Wrapping addition, taken and untaken zero-jumps, and loads of the program's own bytes are all placed in one program. A skipped store there would appear as an unexpected write. Two further programs end on an undefined opcode and on an out-of-range register index. Each has a store after the bad instruction that must never appear.

// File: rtl/cpu_pkg.sv
`timescale 1ns/1ps
package cpu_pkg;
    localparam int DW    = 8;
    localparam int AW    = 8;
    localparam int IW    = 16;
    localparam int FW    = 4;
    localparam int NREG  = 4;
    localparam int RW    = $clog2(NREG);

    localparam logic [FW-1:0] OPC_LOAD  = 4'b0001;
    localparam logic [FW-1:0] OPC_STORE = 4'b0010;
    localparam logic [FW-1:0] OPC_ADD   = 4'b1001;
    localparam logic [FW-1:0] OPC_JMP   = 4'b1010;
    localparam logic [FW-1:0] OPC_JZ    = 4'b1011;
    localparam logic [FW-1:0] OPC_HALT  = 4'b1111;

    typedef enum logic [2:0] {
        ST_FHI, ST_FLO, ST_FWAIT, ST_EXEC, ST_LDWB, ST_STOP
    } state_e;

    typedef enum logic [2:0] {
        K_LOAD, K_STORE, K_ADD, K_JMP, K_JZ, K_STOP
    } kind_e;

    typedef struct packed {
        kind_e           kind;
        logic [RW-1:0]   ra;
        logic [RW-1:0]   rb;
        logic [RW-1:0]   rd;
        logic [AW-1:0]   addr;
    } dec_t;

    typedef struct packed {
        state_e          st;
        logic [AW-1:0]   pc;
        logic [IW-1:0]   ir;
        logic            halted;
    } core_t;
endpackage

// File: rtl/cpu_decode.sv
`timescale 1ns/1ps
module cpu_decode
    import cpu_pkg::*;
(
    input  logic [IW-1:0] ir,
    output dec_t          dec
);
    logic [FW-1:0] opc;
    logic [FW-1:0] fa;
    logic [FW-1:0] fb;
    logic [FW-1:0] fc;
    logic          ok_a;
    logic          ok_b;
    logic          ok_c;

    always_comb begin
        opc  = ir[IW-1 -: FW];
        fa   = ir[IW-FW-1 -: FW];
        fb   = ir[IW-2*FW-1 -: FW];
        fc   = ir[FW-1:0];
        ok_a = (fa < FW'(NREG));
        ok_b = (fb < FW'(NREG));
        ok_c = (fc < FW'(NREG));

        dec.ra   = fa[RW-1:0];
        dec.rb   = fb[RW-1:0];
        dec.rd   = fc[RW-1:0];
        dec.addr = ir[AW-1:0];

        unique case (opc)
            OPC_LOAD:  dec.kind = ok_a ? K_LOAD  : K_STOP;
            OPC_STORE: dec.kind = ok_a ? K_STORE : K_STOP;
            OPC_ADD:   dec.kind = (ok_a && ok_b && ok_c) ? K_ADD : K_STOP;
            OPC_JMP:   dec.kind = K_JMP;
            OPC_JZ:    dec.kind = ok_a ? K_JZ : K_STOP;
            default:   dec.kind = K_STOP;
        endcase
    end
endmodule

// File: rtl/cpu_adder.sv
`timescale 1ns/1ps
module cpu_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    logic [W:0] full;

    always_comb begin
        full = {1'b0, a} + {1'b0, b};
        sum  = full[W-1:0];
    end
endmodule

// File: rtl/cpu_regfile.sv
`timescale 1ns/1ps
module cpu_regfile #(
    parameter int N = 4,
    parameter int W = 8,
    localparam int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [W-1:0]  wr_val,
    input  logic [SW-1:0] rd_sel_a,
    input  logic [SW-1:0] rd_sel_b,
    output logic [W-1:0]  rd_val_a,
    output logic [W-1:0]  rd_val_b
);
    logic [W-1:0] cell_q [N];

    for (genvar g = 0; g < N; g++) begin : g_cell
        logic [W-1:0] cell_d;

        always_comb begin
            cell_d = cell_q[g];
            if (wr_en && (wr_sel == SW'(g))) begin
                cell_d = wr_val;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q[g] <= '0;
            end else begin
                cell_q[g] <= cell_d;
            end
        end
    end

    always_comb begin
        rd_val_a = cell_q[rd_sel_a];
        rd_val_b = cell_q[rd_sel_b];
    end
endmodule

// File: rtl/tiny_cpu.sv
`timescale 1ns/1ps
module tiny_cpu
    import cpu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [DW-1:0] mem_rdata,
    output logic          halted
);
    localparam logic [AW-1:0] PC_STEP = AW'(IW / DW);

    core_t         cur_q;
    core_t         nxt_d;
    dec_t          dec;
    state_e        st_now;
    logic          rf_we;
    logic [RW-1:0] rf_wsel;
    logic [DW-1:0] rf_wval;
    logic [DW-1:0] rf_a;
    logic [DW-1:0] rf_b;
    logic [DW-1:0] sum;

    cpu_decode u_dec (
        .ir  (cur_q.ir),
        .dec (dec)
    );

    cpu_regfile #(.N(NREG), .W(DW)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (rf_we),
        .wr_sel   (rf_wsel),
        .wr_val   (rf_wval),
        .rd_sel_a (dec.ra),
        .rd_sel_b (dec.rb),
        .rd_val_a (rf_a),
        .rd_val_b (rf_b)
    );

    cpu_adder #(.W(DW)) u_add (
        .a   (rf_a),
        .b   (rf_b),
        .sum (sum)
    );

    always_comb begin
        nxt_d     = cur_q;
        mem_addr  = cur_q.pc;
        mem_wdata = rf_a;
        mem_we    = 1'b0;
        rf_we     = 1'b0;
        rf_wsel   = dec.rd;
        rf_wval   = sum;

        unique case (cur_q.st)
            ST_FHI: begin
                nxt_d.st = ST_FLO;
            end
            ST_FLO: begin
                mem_addr              = cur_q.pc + AW'(1);
                nxt_d.ir[IW-1 -: DW]  = mem_rdata;
                nxt_d.st              = ST_FWAIT;
            end
            ST_FWAIT: begin
                nxt_d.ir[DW-1:0] = mem_rdata;
                nxt_d.pc         = cur_q.pc + PC_STEP;
                nxt_d.st         = ST_EXEC;
            end
            ST_EXEC: begin
                nxt_d.st = ST_FHI;
                unique case (dec.kind)
                    K_LOAD: begin
                        mem_addr = dec.addr;
                        nxt_d.st = ST_LDWB;
                    end
                    K_STORE: begin
                        mem_addr = dec.addr;
                        mem_we   = 1'b1;
                    end
                    K_ADD: begin
                        rf_we = 1'b1;
                    end
                    K_JMP: begin
                        nxt_d.pc = dec.addr;
                    end
                    K_JZ: begin
                        if (rf_a == '0) begin
                            nxt_d.pc = dec.addr;
                        end
                    end
                    default: begin
                        nxt_d.halted = 1'b1;
                        nxt_d.st     = ST_STOP;
                    end
                endcase
            end
            ST_LDWB: begin
                rf_we    = 1'b1;
                rf_wsel  = dec.ra;
                rf_wval  = mem_rdata;
                nxt_d.st = ST_FHI;
            end
            default: begin
                nxt_d.st = ST_STOP;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{st: ST_FHI, pc: '0, ir: '0, halted: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign halted = cur_q.halted;
    assign st_now = cur_q.st;
endmodule

// File: rtl/tiny_cpu_chk.sv
`timescale 1ns/1ps
module tiny_cpu_chk
    import cpu_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic          halted,
    input state_e        st_now
);
    AST_RESET_FETCH_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_addr == '0 && !mem_we && !halted)); // R1

    AST_FETCH_NEXT_BYTE: assert property (@(posedge clk) disable iff (rst)
        (st_now == ST_FHI) |=> (mem_addr == AW'($past(mem_addr) + 1'b1))); // R2

    AST_WRITE_ONLY_EXEC: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (st_now == ST_EXEC)); // R4

    AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we); // R4

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted); // R8

    AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we); // R8

    AST_HALT_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(mem_addr)); // R8
endmodule

bind tiny_cpu tiny_cpu_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .halted   (halted),
    .st_now   (st_now)
);

// File: tb/tb_tiny_cpu.sv
`timescale 1ns/1ps
module tb_tiny_cpu;
    typedef struct {
        logic [7:0] a;
        logic [7:0] d;
        string      req;
    } wr_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       mem_we;
    logic [7:0] mem_rdata;
    logic       halted;

    logic       ld_en = 1'b0;
    logic [7:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [7:0] mem [256];

    wr_t expq[$];
    int  drv_total = 0, drv_bad = 0;
    int  mon_total = 0, mon_bad = 0;

    always #5 clk = ~clk;

    tiny_cpu dut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    // monitor: pops expected writes as the core produces them
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && mem_we) begin
                mon_total++;
                if (expq.size() == 0) begin
                    mon_bad++;
                    $display("FAIL R4/R7/R9/R10 unexpected write: actual a=%02h d=%02h expected none",
                             mem_addr, mem_wdata);
                end else begin
                    wr_t e;
                    e = expq.pop_front();
                    if (mem_addr !== e.a || mem_wdata !== e.d) begin
                        mon_bad++;
                        $display("FAIL %s write: actual a=%02h d=%02h expected a=%02h d=%02h",
                                 e.req, mem_addr, mem_wdata, e.a, e.d);
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        drv_total++;
        if (!ok) begin
            drv_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_wr(input logic [7:0] a, input logic [7:0] d, input string req);
        wr_t e;
        e.a = a; e.d = d; e.req = req;
        expq.push_back(e);
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic put(input logic [7:0] a, input logic [15:0] w);
        poke(a, w[15:8]);
        poke(a + 8'd1, w[7:0]);
    endtask

    function automatic logic [15:0] i_ld(input int r, input logic [7:0] a);
        return {4'b0001, 4'(r), a};
    endfunction
    function automatic logic [15:0] i_st(input int r, input logic [7:0] a);
        return {4'b0010, 4'(r), a};
    endfunction
    function automatic logic [15:0] i_add(input int s1, input int s2, input int d);
        return {4'b1001, 4'(s1), 4'(s2), 4'(d)};
    endfunction
    function automatic logic [15:0] i_jmp(input logic [7:0] a);
        return {4'b1010, 4'd3, a};
    endfunction
    function automatic logic [15:0] i_jz(input int r, input logic [7:0] a);
        return {4'b1011, 4'(r), a};
    endfunction
    localparam logic [15:0] I_HALT = 16'hF000;

    // reset, run to halt, then check the resting bus
    task automatic run(input logic [7:0] stop_addr, input string req);
        int n;
        logic [7:0] held;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(mem_addr == 8'h00, "R1 addr", mem_addr, 0);
        chk(mem_we == 1'b0 && halted == 1'b0, "R1 we/halt", {mem_we, halted}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_addr == 8'h01, "R2 second fetch byte", mem_addr, 1);
        n = 0;
        while (!halted && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(halted == 1'b1, {req, " halt reached"}, halted, 1);
        chk(expq.size() == 0, {req, " pending writes"}, expq.size(), 0);
        held = mem_addr;
        chk(held == stop_addr, {req, " resting addr"}, held, stop_addr);
        repeat (10) @(negedge clk);
        chk(mem_addr == held && halted, {"R8 frozen after ", req}, mem_addr, held);
    endtask

    initial begin
        #1500000;
        drv_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", drv_total + mon_total + 1, drv_bad + mon_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            poke(8'(i), 8'h00);
        end
        // program 1: loads, wrap add, jumps, loading own code
        poke(8'h80, 8'hFF);
        poke(8'h81, 8'h01);
        put(8'h00, i_st(0, 8'hA0));
        put(8'h02, i_st(3, 8'hA1));
        put(8'h04, i_ld(1, 8'h80));
        put(8'h06, i_ld(2, 8'h81));
        put(8'h08, i_add(1, 2, 3));
        put(8'h0A, i_st(3, 8'hA2));
        put(8'h0C, i_add(1, 1, 0));
        put(8'h0E, i_st(0, 8'hA3));
        put(8'h10, i_jz(3, 8'h16));
        put(8'h12, i_st(1, 8'hA4));
        put(8'h14, I_HALT);
        put(8'h16, i_jz(1, 8'h1C));
        put(8'h18, i_st(2, 8'hA5));
        put(8'h1A, i_jmp(8'h20));
        put(8'h1C, i_st(1, 8'hA6));
        put(8'h1E, I_HALT);
        put(8'h20, i_ld(2, 8'h00));
        put(8'h22, i_st(2, 8'h30));
        put(8'h24, i_add(2, 1, 1));
        put(8'h26, i_st(1, 8'hA7));
        put(8'h28, I_HALT);
        expect_wr(8'hA0, 8'h00, "R1 R4 reg0 cleared");
        expect_wr(8'hA1, 8'h00, "R1 reg3 cleared");
        expect_wr(8'hA2, 8'h00, "R5 wrap FF+01");
        expect_wr(8'hA3, 8'hFE, "R5 dest field");
        expect_wr(8'hA5, 8'h01, "R7 not taken / R3 load");
        expect_wr(8'h30, 8'h20, "R3 load own code byte / R6");
        expect_wr(8'hA7, 8'h1F, "R5 operand order");
        run(8'h2A, "R8 HALT");

        // program 2: reset clears registers, undefined opcode stops
        put(8'h00, i_st(0, 8'hB1));
        put(8'h02, i_st(2, 8'hB2));
        put(8'h04, 16'h5000);
        put(8'h06, i_st(0, 8'hB3));
        expect_wr(8'hB1, 8'h00, "R1 reg0 cleared after run");
        expect_wr(8'hB2, 8'h00, "R1 reg2 cleared after run");
        run(8'h06, "R9 undefined opcode");

        // program 3: register index out of range stops
        put(8'h00, i_ld(3, 8'h80));
        put(8'h02, i_st(3, 8'hC0));
        put(8'h04, i_add(1, 6, 0));
        put(8'h06, i_st(3, 8'hC1));
        expect_wr(8'hC0, 8'hFF, "R3 R4 load then store");
        run(8'h06, "R10 bad register");

        @(negedge clk);
        $display("test done: total=%0d bad=%0d", drv_total + mon_total, drv_bad + mon_bad);
        $finish;
    end
endmodule